// File: doc/BRIEF.md
# Chip-Select Address Decoder

This block sits at the start of every external bus cycle and decides which device the cycle is for. It holds ten programmable regions. Eight of them drive active-low chip-select lines and two of them select DRAM blocks. Each region has a base address, a don't-care mask, access-type exclusions, a port width, a burst permission and a termination source. When a cycle starts, the block captures the decode result. It then presents the selected lines and the cycle parameters to the bus logic, and keeps them steady until the cycle is reported complete.

The decode result is resolved by fixed rules:
- **Single chip-select hit:** that line is driven and the cycle uses that region's parameters.
- **Single DRAM hit:** that block is selected and the cycle uses that region's parameters.
- **No hit:** the cycle falls back to an external, non-burst, 32-bit cycle.
- **Several chip-select hits:** every hit line is driven, and the cycle is forced to the same fallback parameters.
- **Conflicting hit:** two DRAM blocks, or a DRAM block together with a chip-select, raise an error flag.

Outputs change only on edges where the bus clock is in its low phase.

A four-state machine controls the sequencing. Its states and transitions are:
- **`ST_IDLE`:** goes to `ST_LATCH` when `as_start` is seen, capturing the decode.
- **`ST_LATCH`:** goes to `ST_HOLD` on a low-phase edge, driving the outputs.
- **`ST_HOLD`:** goes to `ST_RELEASE` when `cyc_done` is seen.
- **`ST_RELEASE`:** goes to `ST_IDLE` on a low-phase edge, deasserting everything.

Top module: `cs_addr_decoder`

## Requirements
- R1: After reset, `cs_n` is all ones, `dram_sel` is zero and `dec_valid` is low. Every region is invalid, so the first decode takes the no-hit path.
- R2: A region hits only when three conditions hold. First, its valid bit (ctrl bit 0) is set. Second, `(addr ^ base) & ~mask` is zero. Third, the access is not excluded by its ctrl bits: bit 1 excludes reads (`rw`=1), bit 2 excludes writes (`rw`=0), bit 3 excludes privileged accesses (`priv`=1) and bit 4 excludes user accesses (`priv`=0).
- R3: With exactly one chip-select hit and no DRAM hit, only that `cs_n` bit is low. The parameters come from the region's ctrl fields: `psize` from bits 6:5 (00 = 32-bit, 01 = 8-bit, 10 = 16-bit), `burst_ok` from bit 7 and `int_term` from bit 8.
- R4: With exactly one DRAM hit and no chip-select hit, only that `dram_sel` bit is set, `cs_n` is all ones, and the parameters come from that DRAM region.
- R5: With no hit, `cs_n` is all ones, `dram_sel` is zero, `psize`=00, `burst_ok`=0, `int_term`=0 and `undef_err`=0.
- R6: With two or more chip-select hits and no DRAM hit, every hit line is low, and the parameters are forced to `psize`=00, `burst_ok`=0 and `int_term`=0.
- R7: A hit on both DRAM regions, or on a DRAM region and a chip-select region, sets `undef_err`. The hit lines are still driven, and the parameters fall back to the defaults.
- R8: `as_start` sampled in idle captures the decode. The outputs and `dec_valid` update on the next edge at which `phase_lo` is high. The outputs never change on an edge where `phase_lo` is low.
- R9: While `dec_valid` is high, the outputs stay fixed until `cyc_done` is sampled. Changes on `addr`, `rw` and `priv`, and further `as_start` pulses, have no effect during that time.
- R10: After `cyc_done` is sampled, the next edge with `phase_lo` high deasserts all lines and `dec_valid`.
- R11: A write with `cfg_we` high stores `cfg_wdata` into the region given by `cfg_sel` (0–7 chip-select, 8–9 DRAM). `cfg_field` selects what is written: 0 writes the base, 1 writes the mask, and 2 writes the ctrl bits 8:0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 4 | Region index for the write |
| cfg_field | input | 2 | Field selector: base, mask or ctrl |
| cfg_wdata | input | 32 | Configuration write data |
| as_start | input | 1 | Bus cycle start (address strobe) |
| addr | input | 32 | Cycle address |
| rw | input | 1 | 1 = read, 0 = write |
| priv | input | 1 | 1 = privileged access, 0 = user |
| phase_lo | input | 1 | High when the bus clock is in its low phase |
| cyc_done | input | 1 | Current bus cycle has terminated |
| cs_n | output | 8 | Active-low chip-select lines |
| dram_sel | output | 2 | DRAM block select |
| psize | output | 2 | Port width of the cycle |
| burst_ok | output | 1 | Burst allowed |
| int_term | output | 1 | 1 = internal termination, 0 = external |
| undef_err | output | 1 | Conflicting-hit flag |
| dec_valid | output | 1 | Decode outputs are being presented |

## Verification
Decode patterns are chosen so that each resolution rule is isolated:
- **Single-region hits:** a lone chip-select hit and a lone DRAM hit show whether the parameters come from the right region.
- **Overlapping chip-selects:** an address inside two chip-select windows separates "drive all hit lines with default parameters" from a single-region decode.
- **Attribute exclusion:** the same address with the opposite access direction removes one of the two hits, which shows that the exclusion bits take effect.
- **Conflicts, invalid region and no hit:** DRAM/DRAM and DRAM/chip-select overlaps check the error flag, and an invalid region and an unmapped address check the fallback.

Held-phase address changes, extra start pulses and a stretch with `phase_lo` held low check that the outputs stay frozen.

// File: rtl/csd_pkg.sv
package csd_pkg;

    // Port width codes
    localparam logic [1:0] PS_32 = 2'b00;
    localparam logic [1:0] PS_8  = 2'b01;
    localparam logic [1:0] PS_16 = 2'b10;

    // Configuration field selectors
    localparam logic [1:0] FLD_BASE = 2'd0;
    localparam logic [1:0] FLD_MASK = 2'd1;
    localparam logic [1:0] FLD_CTRL = 2'd2;

    // Per-region control word, bit 0 is valid
    typedef struct packed {
        logic       int_term;   // 8
        logic       burst_ok;   // 7
        logic [1:0] psize;      // 6:5
        logic       no_user;    // 4
        logic       no_priv;    // 3
        logic       no_write;   // 2
        logic       no_read;    // 1
        logic       valid;      // 0
    } region_ctrl_t;

    localparam int CTRL_W = $bits(region_ctrl_t);

    typedef struct packed {
        logic [1:0] psize;
        logic       burst_ok;
        logic       int_term;
    } cyc_param_t;

    localparam cyc_param_t FALLBACK_PARAM = '{psize: PS_32, burst_ok: 1'b0, int_term: 1'b0};

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LATCH,
        ST_HOLD,
        ST_RELEASE
    } dec_state_t;

endpackage

// File: rtl/csd_region_file.sv
module csd_region_file
    import csd_pkg::*;
#(
    parameter int AW   = 32,
    parameter int NREG = 10,
    parameter int SELW = 4
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             cfg_we,
    input  logic [SELW-1:0]                  cfg_sel,
    input  logic [1:0]                       cfg_field,
    input  logic [AW-1:0]                    cfg_wdata,
    output logic [NREG-1:0][AW-1:0]          base_o,
    output logic [NREG-1:0][AW-1:0]          mask_o,
    output region_ctrl_t [NREG-1:0]          ctrl_o
);

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        logic hit_wr;
        assign hit_wr = cfg_we && (cfg_sel == SELW'(g));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                base_o[g] <= '0;
                mask_o[g] <= '0;
                ctrl_o[g] <= '0;
            end else if (hit_wr) begin
                unique case (cfg_field)
                    FLD_BASE: base_o[g] <= cfg_wdata;
                    FLD_MASK: mask_o[g] <= cfg_wdata;
                    FLD_CTRL: ctrl_o[g] <= region_ctrl_t'(cfg_wdata[CTRL_W-1:0]);
                    default:  ;
                endcase
            end
        end
    end

endmodule

// File: rtl/csd_region_match.sv
module csd_region_match
    import csd_pkg::*;
#(
    parameter int AW   = 32,
    parameter int NREG = 10
) (
    input  logic [AW-1:0]           addr,
    input  logic                    rw,
    input  logic                    priv,
    input  logic [NREG-1:0][AW-1:0] base,
    input  logic [NREG-1:0][AW-1:0] mask,
    input  region_ctrl_t [NREG-1:0] ctrl,
    output logic [NREG-1:0]         hit
);

    for (genvar g = 0; g < NREG; g++) begin : g_cmp
        logic addr_ok;
        logic dir_ok;
        logic mode_ok;
        assign addr_ok = ((addr ^ base[g]) & ~mask[g]) == '0;
        assign dir_ok  = rw ? !ctrl[g].no_read : !ctrl[g].no_write;
        assign mode_ok = priv ? !ctrl[g].no_priv : !ctrl[g].no_user;
        assign hit[g]  = ctrl[g].valid && addr_ok && dir_ok && mode_ok;
    end

endmodule

// File: rtl/csd_resolve.sv
module csd_resolve
    import csd_pkg::*;
#(
    parameter int N_CS = 8,
    parameter int N_DR = 2,
    localparam int NREG = N_CS + N_DR
) (
    input  logic [NREG-1:0]         hit,
    input  region_ctrl_t [NREG-1:0] ctrl,
    output logic [N_CS-1:0]         cs_hit,
    output logic [N_DR-1:0]         dram_hit,
    output cyc_param_t              param,
    output logic                    undef
);

    int         cs_cnt;
    int         dr_cnt;
    cyc_param_t cs_or;
    cyc_param_t dr_or;

    assign cs_hit   = hit[N_CS-1:0];
    assign dram_hit = hit[NREG-1:N_CS];

    // Counting and OR-selection; with exactly one hit the OR is that region
    always_comb begin
        cs_cnt = 0;
        dr_cnt = 0;
        cs_or  = '0;
        dr_or  = '0;
        for (int i = 0; i < N_CS; i++) begin
            if (hit[i]) begin
                cs_cnt = cs_cnt + 1;
                cs_or  = cs_or | {ctrl[i].psize, ctrl[i].burst_ok, ctrl[i].int_term};
            end
        end
        for (int j = 0; j < N_DR; j++) begin
            if (hit[N_CS+j]) begin
                dr_cnt = dr_cnt + 1;
                dr_or  = dr_or | {ctrl[N_CS+j].psize, ctrl[N_CS+j].burst_ok,
                                  ctrl[N_CS+j].int_term};
            end
        end
    end

    always_comb begin
        undef = (dr_cnt > 1) || (dr_cnt == 1 && cs_cnt != 0);
        param = FALLBACK_PARAM;
        if (!undef) begin
            if (cs_cnt == 1 && dr_cnt == 0) begin
                param = cs_or;
            end else if (dr_cnt == 1 && cs_cnt == 0) begin
                param = dr_or;
            end
        end
    end

endmodule

// File: rtl/cs_addr_decoder.sv
module cs_addr_decoder
    import csd_pkg::*;
#(
    parameter int AW   = 32,
    parameter int N_CS = 8,
    parameter int N_DR = 2,
    localparam int NREG = N_CS + N_DR,
    localparam int SELW = $clog2(NREG)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [SELW-1:0]  cfg_sel,
    input  logic [1:0]       cfg_field,
    input  logic [AW-1:0]    cfg_wdata,
    input  logic             as_start,
    input  logic [AW-1:0]    addr,
    input  logic             rw,
    input  logic             priv,
    input  logic             phase_lo,
    input  logic             cyc_done,
    output logic [N_CS-1:0]  cs_n,
    output logic [N_DR-1:0]  dram_sel,
    output logic [1:0]       psize,
    output logic             burst_ok,
    output logic             int_term,
    output logic             undef_err,
    output logic             dec_valid
);

    logic [NREG-1:0][AW-1:0] base;
    logic [NREG-1:0][AW-1:0] mask;
    region_ctrl_t [NREG-1:0] ctrl;
    logic [NREG-1:0]         hit;
    logic [N_CS-1:0]         cs_hit;
    logic [N_DR-1:0]         dram_hit;
    cyc_param_t              param;
    logic                    undef;

    // Captured decode
    logic [N_CS-1:0] cs_hit_q;
    logic [N_DR-1:0] dram_hit_q;
    cyc_param_t      param_q;
    logic            undef_q;

    dec_state_t state_q;
    dec_state_t state_d;

    csd_region_file #(.AW(AW), .NREG(NREG), .SELW(SELW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_field (cfg_field),
        .cfg_wdata (cfg_wdata),
        .base_o    (base),
        .mask_o    (mask),
        .ctrl_o    (ctrl)
    );

    csd_region_match #(.AW(AW), .NREG(NREG)) u_match (
        .addr (addr),
        .rw   (rw),
        .priv (priv),
        .base (base),
        .mask (mask),
        .ctrl (ctrl),
        .hit  (hit)
    );

    csd_resolve #(.N_CS(N_CS), .N_DR(N_DR)) u_resolve (
        .hit      (hit),
        .ctrl     (ctrl),
        .cs_hit   (cs_hit),
        .dram_hit (dram_hit),
        .param    (param),
        .undef    (undef)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (as_start) state_d = ST_LATCH;
            ST_LATCH:   if (phase_lo) state_d = ST_HOLD;
            ST_HOLD:    if (cyc_done) state_d = ST_RELEASE;
            ST_RELEASE: if (phase_lo) state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // State register and decode capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            cs_hit_q   <= '0;
            dram_hit_q <= '0;
            param_q    <= FALLBACK_PARAM;
            undef_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && as_start) begin
                cs_hit_q   <= cs_hit;
                dram_hit_q <= dram_hit;
                param_q    <= param;
                undef_q    <= undef;
            end
        end
    end

    // Output register: changes only in the low phase
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_n      <= '1;
            dram_sel  <= '0;
            psize     <= PS_32;
            burst_ok  <= 1'b0;
            int_term  <= 1'b0;
            undef_err <= 1'b0;
            dec_valid <= 1'b0;
        end else begin
            unique case (state_q)
                ST_LATCH: if (phase_lo) begin
                    cs_n      <= ~cs_hit_q;
                    dram_sel  <= dram_hit_q;
                    psize     <= param_q.psize;
                    burst_ok  <= param_q.burst_ok;
                    int_term  <= param_q.int_term;
                    undef_err <= undef_q;
                    dec_valid <= 1'b1;
                end
                ST_RELEASE: if (phase_lo) begin
                    cs_n      <= '1;
                    dram_sel  <= '0;
                    psize     <= PS_32;
                    burst_ok  <= 1'b0;
                    int_term  <= 1'b0;
                    undef_err <= 1'b0;
                    dec_valid <= 1'b0;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/csd_checker.sv
module csd_checker #(
    parameter int N_CS = 8,
    parameter int N_DR = 2
) (
    input logic            clk,
    input logic            rst_n,
    input logic            phase_lo,
    input logic [N_CS-1:0] cs_n,
    input logic [N_DR-1:0] dram_sel,
    input logic [1:0]      psize,
    input logic            burst_ok,
    input logic            int_term,
    input logic            undef_err,
    input logic            dec_valid
);

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_valid |-> ((&cs_n) && dram_sel == '0 && !undef_err));

    // R6
    multi_cs_fallback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(~cs_n) > 1 && dram_sel == '0) |-> (psize == 2'b00 && !burst_ok && !int_term));

    // R7
    conflict_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        undef_err |-> (($countones(dram_sel) > 1) || (dram_sel != '0 && !(&cs_n))));

    // R7
    no_conflict_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !undef_err |-> ($onehot0(dram_sel) && !(dram_sel != '0 && !(&cs_n))));

    // R8
    phase_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(phase_lo) |-> ($stable(cs_n) && $stable(dram_sel) && $stable(dec_valid)));

    // R9
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(dec_valid) && dec_valid) |-> ($stable(cs_n) && $stable(dram_sel) &&
            $stable(psize) && $stable(burst_ok) && $stable(int_term) && $stable(undef_err)));

endmodule

bind cs_addr_decoder csd_checker #(.N_CS(N_CS), .N_DR(N_DR)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .phase_lo  (phase_lo),
    .cs_n      (cs_n),
    .dram_sel  (dram_sel),
    .psize     (psize),
    .burst_ok  (burst_ok),
    .int_term  (int_term),
    .undef_err (undef_err),
    .dec_valid (dec_valid)
);

// File: tb/cs_addr_decoder_test.sv
module cs_addr_decoder_test;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_sel = '0;
    logic [1:0]  cfg_field = '0;
    logic [31:0] cfg_wdata = '0;
    logic        as_start = 1'b0;
    logic [31:0] addr = '0;
    logic        rw = 1'b1;
    logic        priv = 1'b0;
    logic        phase_lo = 1'b1;
    logic        cyc_done = 1'b0;
    logic [7:0]  cs_n;
    logic [1:0]  dram_sel;
    logic [1:0]  psize;
    logic        burst_ok;
    logic        int_term;
    logic        undef_err;
    logic        dec_valid;

    int checks = 0;
    int fails  = 0;

    typedef struct {
        logic [14:0] vec;
        string       req;
    } exp_t;

    exp_t sb[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    cs_addr_decoder uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_field(cfg_field), .cfg_wdata(cfg_wdata), .as_start(as_start),
        .addr(addr), .rw(rw), .priv(priv), .phase_lo(phase_lo),
        .cyc_done(cyc_done), .cs_n(cs_n), .dram_sel(dram_sel), .psize(psize),
        .burst_ok(burst_ok), .int_term(int_term), .undef_err(undef_err),
        .dec_valid(dec_valid)
    );

    function automatic logic [14:0] pack_out();
        return {cs_n, dram_sel, psize, burst_ok, int_term, undef_err};
    endfunction

    function automatic logic [14:0] mk(logic [7:0] c, logic [1:0] d, logic [1:0] p,
                                       logic b, logic t, logic u);
        return {c, d, p, b, t, u};
    endfunction

    task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Monitor: on each rise of dec_valid, pop and compare
    logic prev_valid = 1'b0;
    always @(negedge clk) begin
        if (rst_n && dec_valid && !prev_valid) begin
            if (sb.size() == 0) begin
                check(1'b0, "R8 unexpected decode", 32'(pack_out()), 32'h0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(pack_out() == e.vec, e.req, 32'(pack_out()), 32'(e.vec));
            end
        end
        prev_valid = dec_valid;
    end

    task automatic cfg_write(logic [3:0] sel, logic [1:0] fld, logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_field = fld; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic program_region(logic [3:0] sel, logic [31:0] b, logic [31:0] m, logic [31:0] c);
        cfg_write(sel, 2'd0, b);
        cfg_write(sel, 2'd1, m);
        cfg_write(sel, 2'd2, c);
    endtask

    // Driver: full bus cycle with held-phase disturbance and release check
    task automatic run_cycle(logic [31:0] a, logic r, logic p, logic [14:0] e, string req);
        exp_t item;
        item.vec = e; item.req = req;
        sb.push_back(item);
        @(negedge clk);
        as_start = 1'b1; addr = a; rw = r; priv = p;
        @(negedge clk);              // capture edge passed
        as_start = 1'b0;
        @(negedge clk);              // outputs edge passed, monitor compares
        check(dec_valid === 1'b1, "R8 valid after two edges", 32'(dec_valid), 32'h1);
        // R9: disturb inputs while held
        addr = ~a; rw = ~r; priv = ~p; as_start = 1'b1;
        @(negedge clk);
        as_start = 1'b0;
        @(negedge clk);
        check(pack_out() == e, "R9 held outputs", 32'(pack_out()), 32'(e));
        cyc_done = 1'b1;
        @(negedge clk);
        cyc_done = 1'b0;
        @(negedge clk);
        check(dec_valid == 1'b0 && cs_n == 8'hFF && dram_sel == 2'b00,
              "R10 release", 32'({dec_valid, cs_n, dram_sel}), 32'({1'b0, 8'hFF, 2'b00}));
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        fails++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check(cs_n == 8'hFF && dram_sel == 2'b00 && dec_valid == 1'b0,
              "R1 reset outputs", 32'({cs_n, dram_sel, dec_valid}), 32'({8'hFF, 2'b00, 1'b0}));
        rst_n = 1'b1;
        // R1 / R5: unprogrammed decode takes fallback
        run_cycle(32'h1000_0000, 1'b1, 1'b0, mk(8'hFF, 2'b00, 2'b00, 0, 0, 0), "R1 R5 unprogrammed");

        // R11 programming through the write port
        program_region(4'd0, 32'h1000_0000, 32'h00FF_FFFF, 32'h1C1);
        program_region(4'd1, 32'h2000_0000, 32'h0000_FFFF, 32'h025);
        program_region(4'd2, 32'h2000_0000, 32'h00FF_FFFF, 32'h141);
        program_region(4'd3, 32'h3000_0000, 32'h0FFF_FFFF, 32'h191);
        program_region(4'd4, 32'h4100_0000, 32'h00FF_FFFF, 32'h001);
        program_region(4'd5, 32'h5000_0000, 32'h0000_0000, 32'h000);
        program_region(4'd8, 32'h4000_0000, 32'h0FFF_FFFF, 32'h181);
        program_region(4'd9, 32'h4800_0000, 32'h07FF_FFFF, 32'h181);

        run_cycle(32'h1000_0004, 1'b1, 1'b0, mk(8'hFE, 2'b00, 2'b10, 1, 1, 0), "R3 R11 single cs0");
        run_cycle(32'h2000_1234, 1'b1, 1'b0, mk(8'hF9, 2'b00, 2'b00, 0, 0, 0), "R6 multi cs1 cs2");
        run_cycle(32'h2000_1234, 1'b0, 1'b0, mk(8'hFB, 2'b00, 2'b10, 0, 1, 0), "R2 write excludes cs1");
        run_cycle(32'h2010_0000, 1'b1, 1'b0, mk(8'hFB, 2'b00, 2'b10, 0, 1, 0), "R2 R3 mask cs2 only");
        run_cycle(32'h3000_0040, 1'b1, 1'b0, mk(8'hFF, 2'b00, 2'b00, 0, 0, 0), "R2 R5 user excluded cs3");
        run_cycle(32'h3000_0040, 1'b1, 1'b1, mk(8'hF7, 2'b00, 2'b00, 1, 1, 0), "R3 privileged cs3");
        run_cycle(32'h4000_0010, 1'b1, 1'b0, mk(8'hFF, 2'b01, 2'b00, 1, 1, 0), "R4 dram0");
        run_cycle(32'h4800_0000, 1'b1, 1'b0, mk(8'hFF, 2'b11, 2'b00, 0, 0, 1), "R7 dram dram");
        run_cycle(32'h4100_0000, 1'b1, 1'b0, mk(8'hEF, 2'b01, 2'b00, 0, 0, 1), "R7 dram cs4");
        run_cycle(32'h5000_0000, 1'b1, 1'b0, mk(8'hFF, 2'b00, 2'b00, 0, 0, 0), "R2 invalid cs5");
        run_cycle(32'h9000_0000, 1'b0, 1'b1, mk(8'hFF, 2'b00, 2'b00, 0, 0, 0), "R5 no hit");

        // R8: phase_lo low holds the outputs back
        begin
            exp_t item;
            item.vec = mk(8'hFE, 2'b00, 2'b10, 1, 1, 0);
            item.req = "R8 delayed by phase";
            sb.push_back(item);
        end
        @(negedge clk);
        as_start = 1'b1; addr = 32'h1000_0100; rw = 1'b1; priv = 1'b0; phase_lo = 1'b0;
        @(negedge clk);
        as_start = 1'b0;
        repeat (3) @(negedge clk);
        check(dec_valid == 1'b0 && cs_n == 8'hFF, "R8 gated while phase high",
              32'({dec_valid, cs_n}), 32'({1'b0, 8'hFF}));
        phase_lo = 1'b1;
        @(negedge clk);
        check(dec_valid == 1'b1, "R8 valid after phase", 32'(dec_valid), 32'h1);
        // R10 with phase gating on release
        cyc_done = 1'b1; phase_lo = 1'b0;
        @(negedge clk);
        cyc_done = 1'b0;
        @(negedge clk);
        check(dec_valid == 1'b1 && cs_n == 8'hFE, "R10 release waits for phase",
              32'({dec_valid, cs_n}), 32'({1'b1, 8'hFE}));
        phase_lo = 1'b1;
        @(negedge clk);
        check(dec_valid == 1'b0 && cs_n == 8'hFF, "R10 released",
              32'({dec_valid, cs_n}), 32'({1'b0, 8'hFF}));

        repeat (2) @(negedge clk);
        check(sb.size() == 0, "R8 all decodes seen", 32'(sb.size()), 32'h0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule